// File: doc/BRIEF.md
# Ethernet Transmit Abort and Status Monitor

This block follows a single transmit attempt of an Ethernet MAC from its start strobe to its end strobe and builds a 32-bit status word for that frame. The word reports a clean delivery, the address class of the destination, and any of four abort causes:

- a collision after the programmable collision window,
- more collisions than the retry limit allows,
- a deferral longer than a speed-dependent limit,
- a transmit FIFO underrun.

When any abort occurs, a halt output stops the transmit write path from taking further frames. A sticky error interrupt is raised at the same time. Both stay set until software pulses the clear input.

The collision window is compared against the byte offset reported with each collision. Deferral is counted in nibble times: the counter advances on nibble ticks that arrive while carrier is sensed. The deferral abort can be switched off by configuration, in which case the frame simply keeps deferring.

Top module: `txAbortMon`

## Requirements
- R1: After reset the status word is zero and both the halt and error interrupt outputs are low.
- R2: An end strobe on an active frame with no abort in that cycle sets bit 15 one cycle later, and the frame ends. Bits 31:16 always read zero.
- R3: Bit 14 is set at frame start when all 48 destination bits are ones.
- R4: Bit 13 is set at frame start when destination bit 40 (the least significant bit of the first transmitted byte, which sits in bits 47:40) is one and the address is not broadcast.
- R5: A collision whose offset is greater than the collision window sets bit 12 and aborts. A collision at an offset equal to or below the window only counts toward the retry limit.
- R6: With retry limit L, the in-window collision that makes the frame's count exceed L sets bit 10 and aborts.
- R7: Deferral aborts and sets bit 11 on the first counted nibble beyond 6071 in 100 Mbps mode (speed input 1), or beyond 24287 in 10 Mbps mode (speed input 0).
- R8: While the deferral-disable input is 1, no amount of deferral sets bit 11, halts or raises the interrupt.
- R9: A FIFO underrun during an active frame sets bit 9 and aborts.
- R10: Any abort sets the halt and interrupt outputs. They stay set until a clear pulse. Start strobes while halted are ignored and leave the status word unchanged.
- R11: Abort causes in the same cycle set all their bits together. Bit 15 is never set on a frame that aborted, even if the end strobe coincides with the abort.
- R12: Each accepted start clears the previous status and restarts the collision and deferral counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | Start of a transmit attempt |
| frameEnd | input | 1 | Frame fully emptied from the FIFO |
| nibbleTick | input | 1 | One pulse per nibble time |
| carrierSense | input | 1 | Medium busy, so the frame is deferring |
| collision | input | 1 | Collision seen this cycle |
| collOffset | input | 11 | Byte offset of the collision |
| fifoUnderrun | input | 1 | Transmit FIFO ran empty |
| destAddr | input | 48 | Destination address, first byte in bits 47:40 |
| cfgCollWindow | input | 11 | Last byte offset at which a collision is not late |
| cfgRetryLimit | input | 4 | Collisions allowed before the excessive-collision abort |
| cfgSpeed100 | input | 1 | 1 for 100 Mbps, 0 for 10 Mbps |
| cfgNoDeferAbort | input | 1 | 1 disables the excessive-deferral abort |
| swClear | input | 1 | Clears halt and interrupt |
| statusWord | output | 32 | Per-frame status |
| txErrIrq | output | 1 | Sticky transmit error interrupt |
| txHalt | output | 1 | Stop further frame processing |

## Verification
The assertions assume that configuration is held steady across a frame. They also assume that strobes are single-cycle pulses and that `swClear` is never pulsed in the same cycle as an abort. The stimulus respects all three: configuration changes only between frames, every strobe is driven for exactly one clock, and clears are issued only after the abort is already visible on the outputs. Under those conditions the checker relies on three properties: the halt can only be released by a clear, an abort always shows up together with the halt, and the status bits never contradict each other.

// File: rtl/txAbortPkg.sv
package txAbortPkg;
  localparam int ST_OK    = 15;
  localparam int ST_BCAST = 14;
  localparam int ST_MCAST = 13;
  localparam int ST_LATE  = 12;
  localparam int ST_DEFER = 11;
  localparam int ST_RETRY = 10;
  localparam int ST_UNDER = 9;

  typedef struct packed {
    logic clrFrame;
    logic setOk;
    logic setLate;
    logic setRetry;
    logic setDefer;
    logic setUnder;
    logic bumpColl;
    logic bumpDefer;
  } ctrlStrobes_t;
endpackage

// File: rtl/txAbortCtrl.sv
module txAbortCtrl
  import txAbortPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameStart,
  input  logic         frameEnd,
  input  logic         deferTick,
  input  logic         collision,
  input  logic         fifoUnderrun,
  input  logic         lateHit,
  input  logic         retryHit,
  input  logic         deferHit,
  input  logic         swClear,
  output ctrlStrobes_t strb,
  output logic         txHalt,
  output logic         txErrIrq
);
  logic activeQ, haltQ, irqQ;
  logic accept, evtOn, anyAbort;

  always_comb begin
    accept   = frameStart && !haltQ;
    evtOn    = activeQ && !accept;
    strb              = '0;
    strb.clrFrame     = accept;
    strb.setLate      = evtOn && collision && lateHit;
    strb.setRetry     = evtOn && collision && !lateHit && retryHit;
    strb.setDefer     = evtOn && deferTick && deferHit;
    strb.setUnder     = evtOn && fifoUnderrun;
    anyAbort          = strb.setLate || strb.setRetry || strb.setDefer || strb.setUnder;
    strb.setOk        = evtOn && frameEnd && !anyAbort;
    strb.bumpColl     = evtOn && collision && !lateHit;
    strb.bumpDefer    = evtOn && deferTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      haltQ   <= 1'b0;
      irqQ    <= 1'b0;
    end else begin
      if (accept)                      activeQ <= 1'b1;
      else if (anyAbort || strb.setOk) activeQ <= 1'b0;
      if (anyAbort) begin
        haltQ <= 1'b1;
        irqQ  <= 1'b1;
      end else if (swClear) begin
        haltQ <= 1'b0;
        irqQ  <= 1'b0;
      end
    end
  end

  assign txHalt   = haltQ;
  assign txErrIrq = irqQ;
endmodule

// File: rtl/txAbortDp.sv
module txAbortDp
  import txAbortPkg::*;
#(
  parameter int OFS_W      = 11,
  parameter int RETRY_W    = 4,
  parameter int DEFER_FAST = 6071,
  parameter int DEFER_SLOW = 24287
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [47:0]        destAddr,
  input  logic [OFS_W-1:0]   collOffset,
  input  logic [OFS_W-1:0]   cfgCollWindow,
  input  logic [RETRY_W-1:0] cfgRetryLimit,
  input  logic               cfgSpeed100,
  input  logic               cfgNoDeferAbort,
  output logic               lateHit,
  output logic               retryHit,
  output logic               deferHit,
  output logic [31:0]        statusWord
);
  localparam int COLL_W  = RETRY_W + 1;
  localparam int DEFMAX  = (DEFER_FAST > DEFER_SLOW) ? DEFER_FAST : DEFER_SLOW;
  localparam int DEFER_W = $clog2(DEFMAX + 2);
  localparam logic [DEFER_W-1:0] LIM_FAST = DEFER_W'(DEFER_FAST);
  localparam logic [DEFER_W-1:0] LIM_SLOW = DEFER_W'(DEFER_SLOW);

  logic [COLL_W-1:0]  collCnt;
  logic [DEFER_W-1:0] deferCnt;
  logic [DEFER_W-1:0] deferLim;
  logic [15:0]        statQ;
  logic               isBcast, isMcast;

  always_comb begin
    deferLim = cfgSpeed100 ? LIM_FAST : LIM_SLOW;
    lateHit  = collOffset > cfgCollWindow;
    retryHit = collCnt >= COLL_W'(cfgRetryLimit);
    deferHit = !cfgNoDeferAbort && (deferCnt >= deferLim);
    isBcast  = &destAddr;
    isMcast  = destAddr[40] && !isBcast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      collCnt  <= '0;
      deferCnt <= '0;
    end else if (strb.clrFrame) begin
      collCnt  <= '0;
      deferCnt <= '0;
    end else begin
      if (strb.bumpColl && !(&collCnt))   collCnt  <= collCnt + 1'b1;
      if (strb.bumpDefer && !(&deferCnt)) deferCnt <= deferCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= '0;
    end else if (strb.clrFrame) begin
      statQ           <= '0;
      statQ[ST_BCAST] <= isBcast;
      statQ[ST_MCAST] <= isMcast;
    end else begin
      if (strb.setOk)    statQ[ST_OK]    <= 1'b1;
      if (strb.setLate)  statQ[ST_LATE]  <= 1'b1;
      if (strb.setDefer) statQ[ST_DEFER] <= 1'b1;
      if (strb.setRetry) statQ[ST_RETRY] <= 1'b1;
      if (strb.setUnder) statQ[ST_UNDER] <= 1'b1;
    end
  end

  assign statusWord = {16'h0000, statQ};
endmodule

// File: rtl/txAbortMon.sv
module txAbortMon
  import txAbortPkg::*;
#(
  parameter int OFS_W      = 11,
  parameter int RETRY_W    = 4,
  parameter int DEFER_FAST = 6071,
  parameter int DEFER_SLOW = 24287
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               frameEnd,
  input  logic               nibbleTick,
  input  logic               carrierSense,
  input  logic               collision,
  input  logic [OFS_W-1:0]   collOffset,
  input  logic               fifoUnderrun,
  input  logic [47:0]        destAddr,
  input  logic [OFS_W-1:0]   cfgCollWindow,
  input  logic [RETRY_W-1:0] cfgRetryLimit,
  input  logic               cfgSpeed100,
  input  logic               cfgNoDeferAbort,
  input  logic               swClear,
  output logic [31:0]        statusWord,
  output logic               txErrIrq,
  output logic               txHalt
);
  ctrlStrobes_t strb;
  logic lateHit, retryHit, deferHit;

  txAbortCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .deferTick(nibbleTick && carrierSense), .collision(collision),
    .fifoUnderrun(fifoUnderrun), .lateHit(lateHit), .retryHit(retryHit),
    .deferHit(deferHit), .swClear(swClear), .strb(strb),
    .txHalt(txHalt), .txErrIrq(txErrIrq)
  );

  txAbortDp #(
    .OFS_W(OFS_W), .RETRY_W(RETRY_W),
    .DEFER_FAST(DEFER_FAST), .DEFER_SLOW(DEFER_SLOW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .destAddr(destAddr),
    .collOffset(collOffset), .cfgCollWindow(cfgCollWindow),
    .cfgRetryLimit(cfgRetryLimit), .cfgSpeed100(cfgSpeed100),
    .cfgNoDeferAbort(cfgNoDeferAbort), .lateHit(lateHit),
    .retryHit(retryHit), .deferHit(deferHit), .statusWord(statusWord)
  );
endmodule

// File: rtl/txAbortChk.sv
module txAbortChk (
  input logic        clk,
  input logic        rstN,
  input logic        frameStart,
  input logic        swClear,
  input logic [31:0] statusWord,
  input logic        txErrIrq,
  input logic        txHalt
);
  // R10: halt only released by a clear pulse
  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txHalt && !swClear) |=> txHalt);

  // R10: halt and interrupt move together
  assert_halt_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    txHalt |-> txErrIrq);

  // R10: start strobes while halted leave status untouched
  assert_halted_ignore_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txHalt && frameStart) |=> $stable(statusWord));

  // R11: clean delivery never coexists with an abort bit
  assert_ok_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[15] |-> (statusWord[12:9] == 4'b0000));

  // R9: an abort bit appearing brings the halt with it
  assert_abort_halts_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|statusWord[12:9]) |-> txHalt);

  // R4: broadcast and multicast never both reported
  assert_class_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(statusWord[14:13]) <= 1);

  // R2: upper half reads zero
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[31:16] == 16'h0000);
endmodule

bind txAbortMon txAbortChk u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .swClear(swClear),
  .statusWord(statusWord), .txErrIrq(txErrIrq), .txHalt(txHalt)
);

// File: tb/txAbortMon_tb.sv
module txAbortMon_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 0, frameEnd = 0, nibbleTick = 0, carrierSense = 0;
  logic collision = 0, fifoUnderrun = 0, swClear = 0;
  logic [10:0] collOffset = '0, cfgCollWindow = 11'd64;
  logic [3:0]  cfgRetryLimit = 4'd3;
  logic cfgSpeed100 = 1'b1, cfgNoDeferAbort = 1'b0;
  logic [47:0] destAddr = '0;
  logic [31:0] statusWord;
  logic txErrIrq, txHalt;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  txAbortMon u_dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .nibbleTick(nibbleTick), .carrierSense(carrierSense), .collision(collision),
    .collOffset(collOffset), .fifoUnderrun(fifoUnderrun), .destAddr(destAddr),
    .cfgCollWindow(cfgCollWindow), .cfgRetryLimit(cfgRetryLimit),
    .cfgSpeed100(cfgSpeed100), .cfgNoDeferAbort(cfgNoDeferAbort),
    .swClear(swClear), .statusWord(statusWord), .txErrIrq(txErrIrq), .txHalt(txHalt)
  );

  localparam int NV = 6;
  localparam logic [47:0] VEC_DEST [NV] = '{48'h001122334455, 48'hFFFFFFFFFFFF,
    48'h01005E000001, 48'hFEFFFFFFFFFF, 48'hFFFFFFFFFFFE, 48'h03AABBCCDDEE};
  localparam int VEC_COLL [NV] = '{0, 1, 2, 3, 0, 1};
  localparam logic [31:0] VEC_EXP [NV] = '{32'h8000, 32'hC000, 32'hA000,
    32'h8000, 32'hA000, 32'hA000};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startFrame(logic [47:0] d);
    destAddr = d; frameStart = 1; cyc(1); frameStart = 0;
  endtask

  task automatic pulseColl(logic [10:0] ofs);
    collOffset = ofs; collision = 1; cyc(1); collision = 0;
  endtask

  task automatic endFrame();
    frameEnd = 1; cyc(1); frameEnd = 0;
  endtask

  task automatic clearHalt();
    swClear = 1; cyc(1); swClear = 0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    cyc(2);
    // R1: reset state
    check("R1 status", statusWord, 32'h0);
    check("R1 halt/irq", {30'h0, txHalt, txErrIrq}, 32'h0);
    rstN = 1; cyc(1);

    // R2 R3 R4: table of clean frames
    for (int i = 0; i < NV; i++) begin
      startFrame(VEC_DEST[i]);
      for (int c = 0; c < VEC_COLL[i]; c++) pulseColl(11'd10);
      endFrame();
      check($sformatf("R2/R3/R4 vec%0d", i), statusWord, VEC_EXP[i]);
    end
    check("R2 no halt", {31'h0, txHalt}, 32'h0);

    // R5: window boundary then late collision
    startFrame(48'h001122334455);
    pulseColl(11'd64);
    check("R5 at window", {statusWord[31:0]}, 32'h0);
    check("R5 at window no halt", {31'h0, txHalt}, 32'h0);
    pulseColl(11'd65);
    check("R5 late", statusWord, 32'h1000);
    check("R10 halt after late", {30'h0, txHalt, txErrIrq}, 32'h3);

    // R10: start ignored while halted, clear releases
    startFrame(48'hFFFFFFFFFFFF);
    check("R10 ignored start", statusWord, 32'h1000);
    clearHalt();
    check("R10 cleared", {30'h0, txHalt, txErrIrq}, 32'h0);
    check("R10 status kept", statusWord, 32'h1000);

    // R12 R6: new frame clears status, retry limit 3 -> 4th aborts
    startFrame(48'h01005E000001);
    check("R12 clear on start", statusWord, 32'h2000);
    pulseColl(11'd5); pulseColl(11'd5); pulseColl(11'd5);
    check("R6 at limit", statusWord, 32'h2000);
    pulseColl(11'd5);
    check("R6 retry abort", statusWord, 32'h2400);
    clearHalt();

    // R12: counts restart per frame
    startFrame(48'h001122334455);
    pulseColl(11'd5); pulseColl(11'd5); pulseColl(11'd5);
    endFrame();
    check("R12 count restarted", statusWord, 32'h8000);

    // R9 R11: underrun + late collision together with end strobe
    startFrame(48'h001122334455);
    fifoUnderrun = 1; collOffset = 11'd200; collision = 1; frameEnd = 1;
    cyc(1);
    fifoUnderrun = 0; collision = 0; frameEnd = 0;
    check("R11 both bits no ok", statusWord, 32'h1200);
    check("R9 halt", {31'h0, txHalt}, 32'h1);
    clearHalt();

    // R9: underrun alone
    startFrame(48'h001122334455);
    fifoUnderrun = 1; cyc(1); fifoUnderrun = 0;
    check("R9 underrun", statusWord, 32'h0200);
    clearHalt();

    // R7: 100 Mbps limit
    cfgSpeed100 = 1;
    startFrame(48'h001122334455);
    carrierSense = 1; nibbleTick = 1;
    cyc(6071);
    check("R7 fast at limit", statusWord, 32'h0);
    cyc(1);
    carrierSense = 0; nibbleTick = 0;
    check("R7 fast abort", statusWord, 32'h0800);
    clearHalt();

    // R7: 10 Mbps limit, ticks without carrier do not count
    cfgSpeed100 = 0;
    startFrame(48'h001122334455);
    nibbleTick = 1; cyc(30000); nibbleTick = 0;
    check("R7 no carrier no count", statusWord, 32'h0);
    carrierSense = 1; nibbleTick = 1;
    cyc(24287);
    check("R7 slow at limit", statusWord, 32'h0);
    cyc(1);
    carrierSense = 0; nibbleTick = 0;
    check("R7 slow abort", statusWord, 32'h0800);
    clearHalt();

    // R8: deferral abort disabled
    cfgSpeed100 = 1; cfgNoDeferAbort = 1;
    startFrame(48'h001122334455);
    carrierSense = 1; nibbleTick = 1;
    cyc(7000);
    carrierSense = 0; nibbleTick = 0;
    check("R8 no defer abort", statusWord, 32'h0);
    check("R8 no halt/irq", {30'h0, txHalt, txErrIrq}, 32'h0);
    endFrame();
    check("R8 frame completes", statusWord, 32'h8000);

    done = 1;
    finishRun();
  end
endmodule